// File: doc/BRIEF.md
# Biphase-Mark Serial Audio Transmitter

This block turns a stream of stored 56-bit frame records back into a consumer serial digital audio line signal. Each record holds two 28-bit subframe payloads, left then right. For each subframe the block generates the 4-slot sync pattern itself. It then sends the 28 payload slots in biphase-mark code. A frame takes 128 enabled clock cycles, and each cycle is one half of a bit cell. The clock enable is meant to follow the recovered 128x-sample-rate clock, so the output rate matches the input rate exactly.

The block reads the next record in the cycle that ends the current frame. If no record is offered at that point, it sends a filler frame so that the framing and the 192-frame block count stay unbroken. Sync patterns are not stored. The block keeps its own frame counter to decide which left subframe gets the block-start pattern. It inverts each pattern when the line is high, so that the pattern always begins with a level change. The parity slot is always recomputed.

Top module: `bmc_spdif_tx`

## Requirements
- R1: While reset is held, and in the first cycle after it, `sdo` is low. The first frame sent after reset is frame 0 of a block.
- R2: `rec_ready` is high only in a cycle with `ce` high that ends a frame: once at the first enabled cycle after reset, then once every 128 enabled cycles. A record is taken when `rec_valid` and `rec_ready` are both high, and it is sent in the next 128 enabled cycles.
- R3: A cycle with `ce` low changes nothing. `sdo` holds its level and `rec_ready` stays low.
- R4: Each payload slot is two half-cells. The line changes level at the start of every slot. A 1 adds a second change between its two half-cells and a 0 does not. Record bits [27:0] form the left subframe and bits [55:28] the right. Within a subframe, bit k goes out in slot 4+k, so audio bits 0..23 go out LSB first, then bit 24 (unusable flag), bit 25 (user), bit 26 (channel status) and bit 27 (parity).
- R5: Each subframe opens with 8 half-cells of sync pattern. When the line was low before it, the patterns are 11101000 for block start, 11100010 for a left subframe and 11100100 for a right subframe, first half-cell first. When the line was high, the pattern is inverted.
- R6: The block-start pattern goes on the left subframe of every frame whose index modulo 192 is 0. Every other left subframe gets the left pattern, and every right subframe gets the right pattern.
- R7: The block discards the parity bit (bit 27) of the record and sends even parity over slots 4..31 of each subframe.
- R8: When `rec_ready` is high and `rec_valid` is low, the block sends a filler frame. In both subframes the audio is zero, the unusable flag is 1, user and channel status are 0 and parity is 1. The filler frame still advances the block count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Half-cell enable, high once per recovered clock period |
| rec_valid | input | 1 | A frame record is offered |
| rec_ready | output | 1 | Record taken in this cycle if offered |
| rec_data | input | 56 | Frame record: left payload [27:0], right payload [55:28] |
| sdo | output | 1 | Biphase-mark serial line |

## Verification
The block-start pattern choice and the record hand-off happen in the same enabled cycle. The bench holds `rec_valid` low across the frame-192 boundary, so frame 192 is at once a filler frame and the frame that needs the block-start pattern. The decoder checks both the pattern and the filler payload. The bench also changes `ce` mid-frame during a stretch of frames, so a stalled cycle can fall directly on a frame boundary. The pattern, parity and hand-off timing must still come out unchanged.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    localparam int PAY_BITS      = 28;
    localparam int SLOTS_PER_SUB = 32;
    localparam int HALVES_PER_SUB = 2 * SLOTS_PER_SUB;
    localparam int HALVES_PER_FRAME = 2 * HALVES_PER_SUB;
    localparam int SUB_W         = $clog2(HALVES_PER_SUB);
    localparam int SLOT_W        = $clog2(SLOTS_PER_SUB);
    localparam int SYNC_SLOTS    = 4;
    localparam int SYNC_HALVES   = 2 * SYNC_SLOTS;
    localparam int FRAME_BITS    = 2 * PAY_BITS;

    typedef struct packed {
        logic        par;
        logic        chs;
        logic        usr;
        logic        unusable;
        logic [23:0] audio;
    } sub_t;

    typedef struct packed {
        sub_t right;
        sub_t left;
    } frame_t;

    typedef enum logic [1:0] {
        SYNC_BLOCK = 2'd0,
        SYNC_LEFT  = 2'd1,
        SYNC_RIGHT = 2'd2
    } sync_e;

    function automatic logic [SYNC_HALVES-1:0] sync_pattern(sync_e kind);
        case (kind)
            SYNC_BLOCK: return 8'b1110_1000;
            SYNC_LEFT:  return 8'b1110_0010;
            default:    return 8'b1110_0100;
        endcase
    endfunction

    function automatic sub_t seal(sub_t s);
        sub_t r;
        r     = s;
        r.par = ^{s.chs, s.usr, s.unusable, s.audio};
        return r;
    endfunction

    function automatic frame_t filler_frame();
        frame_t f;
        f                = '0;
        f.left.unusable  = 1'b1;
        f.right.unusable = 1'b1;
        f.left           = seal(f.left);
        f.right          = seal(f.right);
        return f;
    endfunction

endpackage

// File: rtl/bmc_slot_timer.sv
module bmc_slot_timer #(
    parameter int HALVES = 128,
    parameter int FRAMES = 192
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ce,
    output logic [$clog2(HALVES)-1:0] hc_q,
    output logic [$clog2(HALVES)-1:0] nxt_hc,
    output logic                      frame_end,
    output logic                      blk_next
);
    localparam int HW = $clog2(HALVES);
    localparam int FW = $clog2(FRAMES);
    localparam logic [HW-1:0] HC_LAST  = HW'(HALVES - 1);
    localparam logic [FW-1:0] FRM_LAST = FW'(FRAMES - 1);

    logic [FW-1:0] frm_q;

    assign frame_end = (hc_q == HC_LAST);
    assign nxt_hc    = frame_end ? '0 : hc_q + 1'b1;
    // The frame that the next half-cell belongs to is frame 0 of a block
    assign blk_next  = frame_end ? (frm_q == FRM_LAST) : (frm_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hc_q  <= HC_LAST;
            frm_q <= FRM_LAST;
        end else if (ce) begin
            hc_q <= nxt_hc;
            if (frame_end)
                frm_q <= (frm_q == FRM_LAST) ? '0 : frm_q + 1'b1;
        end
    end
endmodule

// File: rtl/bmc_frame_loader.sv
module bmc_frame_loader
    import bmc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  take,
    input  logic                  rec_valid,
    input  logic [FRAME_BITS-1:0] rec_data,
    output frame_t                use_frame
);
    frame_t cur_q;
    frame_t incoming;

    always_comb begin
        incoming       = rec_valid ? frame_t'(rec_data) : filler_frame();
        incoming.left  = seal(incoming.left);
        incoming.right = seal(incoming.right);
    end

    // In the hand-off cycle the new record drives the first half-cell directly
    assign use_frame = take ? incoming : cur_q;

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= filler_frame();
        else if (take)
            cur_q <= incoming;
    end
endmodule

// File: rtl/bmc_line_encoder.sv
module bmc_line_encoder
    import bmc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ce,
    input  logic [SUB_W:0]         nxt_hc,
    input  logic                   blk_next,
    input  frame_t                 frm,
    output logic                   line_q
);
    logic [SUB_W-1:0]        pos;
    logic                    in_right;
    sub_t                    cur_sub;
    logic [SLOT_W-1:0]       slot;
    logic [SLOT_W-1:0]       didx;
    logic [SLOTS_PER_SUB-1:0] sub_bits;
    sync_e                   kind;
    logic [SYNC_HALVES-1:0]  pat;
    logic                    inv_q;
    logic                    ref_lvl;
    logic                    lvl;

    always_comb begin
        pos      = nxt_hc[SUB_W-1:0];
        in_right = nxt_hc[SUB_W];
        cur_sub  = in_right ? frm.right : frm.left;
        slot     = pos[SUB_W-1:1];
        didx     = slot - SLOT_W'(SYNC_SLOTS);
        sub_bits = {{(SLOTS_PER_SUB - PAY_BITS){1'b0}}, cur_sub};
        kind     = in_right ? SYNC_RIGHT : (blk_next ? SYNC_BLOCK : SYNC_LEFT);
        pat      = sync_pattern(kind);
        ref_lvl  = (pos == '0) ? line_q : inv_q;
        if (slot < SLOT_W'(SYNC_SLOTS))
            lvl = pat[3'(SYNC_HALVES - 1) - pos[2:0]] ^ ref_lvl;
        else if (!pos[0])
            lvl = ~line_q;
        else
            lvl = sub_bits[didx] ? ~line_q : line_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
            inv_q  <= 1'b0;
        end else if (ce) begin
            line_q <= lvl;
            if (pos == '0)
                inv_q <= line_q;
        end
    end
endmodule

// File: rtl/bmc_spdif_tx.sv
module bmc_spdif_tx
    import bmc_pkg::*;
#(
    parameter int FRAMES_PER_BLOCK = 192
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce,
    input  logic                  rec_valid,
    output logic                  rec_ready,
    input  logic [FRAME_BITS-1:0] rec_data,
    output logic                  sdo
);
    localparam int HW = $clog2(HALVES_PER_FRAME);

    logic [HW-1:0] hc_q;
    logic [HW-1:0] nxt_hc;
    logic          frame_end;
    logic          blk_next;
    frame_t        use_frame;

    assign rec_ready = ce && frame_end;

    bmc_slot_timer #(
        .HALVES (HALVES_PER_FRAME),
        .FRAMES (FRAMES_PER_BLOCK)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .ce        (ce),
        .hc_q      (hc_q),
        .nxt_hc    (nxt_hc),
        .frame_end (frame_end),
        .blk_next  (blk_next)
    );

    bmc_frame_loader u_loader (
        .clk       (clk),
        .rst       (rst),
        .take      (rec_ready),
        .rec_valid (rec_valid),
        .rec_data  (rec_data),
        .use_frame (use_frame)
    );

    bmc_line_encoder u_enc (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .nxt_hc   (nxt_hc),
        .blk_next (blk_next),
        .frm      (use_frame),
        .line_q   (sdo)
    );
endmodule

// File: rtl/bmc_spdif_tx_chk.sv
module bmc_spdif_tx_chk #(
    parameter int HALVES = 128
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      ce,
    input logic                      rec_valid,
    input logic                      rec_ready,
    input logic                      sdo,
    input logic [$clog2(HALVES)-1:0] hc
);
    localparam int CW = $clog2(HALVES);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= CW'(HALVES - 1);
        else if (ce)
            cnt_q <= cnt_q + 1'b1;
    end

    assert_idle_low_R1: assert property (@(posedge clk) $fell(rst) |-> !sdo)
        else $error("sdo not low after reset");

    assert_ready_period_R2: assert property (@(posedge clk) disable iff (rst)
        rec_ready |-> (cnt_q == CW'(HALVES - 1)))
        else $error("rec_ready off its 128-cycle grid");

    assert_no_ready_R3: assert property (@(posedge clk) disable iff (rst)
        !ce |-> !rec_ready)
        else $error("rec_ready without enable");

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(sdo))
        else $error("sdo moved in a stalled cycle");

    assert_cell_edge_R4: assert property (@(posedge clk) disable iff (rst)
        (ce && hc[0] && !(hc[5:0] inside {6'd1, 6'd3, 6'd5})) |=> (sdo != $past(sdo)))
        else $error("missing cell-start transition");

    assert_sync_flat_R5: assert property (@(posedge clk) disable iff (rst)
        (ce && (hc[5:0] inside {6'd0, 6'd1})) |=> $stable(sdo))
        else $error("sync pattern head not three half-cells wide");
endmodule

bind bmc_spdif_tx bmc_spdif_tx_chk #(.HALVES(128)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .sdo       (sdo),
    .hc        (hc_q)
);

// File: tb/bmc_spdif_tx_tb.sv
module bmc_spdif_tx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b1;
    logic        rec_valid = 1'b0;
    logic        rec_ready;
    logic [55:0] rec_data = '0;
    logic        sdo;

    int checks = 0;
    int fails = 0;
    int ce_mode = 0;
    int ce_cyc = 0;
    int hs_cnt = 0;
    bit done = 0;

    logic [55:0] exp_q[$];
    logic        lv[128];
    int          hc = 0;
    int          fidx = 0;
    bit          pend_ce = 0;
    bit          pend_start = 0;
    bit          started = 0;
    logic        last_sdo = 1'b0;
    logic        pre_frame_lvl = 1'b0;

    always #4 clk = ~clk;

    bmc_spdif_tx u_dut (
        .clk(clk), .rst(rst), .ce(ce), .rec_valid(rec_valid),
        .rec_ready(rec_ready), .rec_data(rec_data), .sdo(sdo)
    );

    function automatic logic [27:0] sub_exp(logic [27:0] s);
        logic [27:0] r;
        r     = s;
        r[27] = ^s[26:0];
        return r;
    endfunction

    function automatic logic [55:0] exp_of(logic [55:0] d);
        return {sub_exp(d[55:28]), sub_exp(d[27:0])};
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // enable pattern
    initial begin
        forever begin
            @(posedge clk);
            #2;
            ce = (ce_mode == 0) ? 1'b1 : ((ce_cyc % 3) != 2);
            ce_cyc++;
        end
    end

    // monitor: outputs for the previous edge first, then capture the next hand-off
    always @(negedge clk) begin
        if (pend_ce) begin
            hc = pend_start ? 0 : hc + 1;
            if (pend_start) pre_frame_lvl = last_sdo;
            lv[hc] = sdo;
            if (hc == 127) decode_frame();
        end else if (started) begin
            check(sdo == last_sdo, "R3 hold", 64'(sdo), 64'(last_sdo));
        end
        last_sdo = sdo;
        pend_ce = ce && !rst;
        pend_start = ce && !rst && rec_ready;
        if (pend_start) begin
            started = 1;
            // R8: a hand-off without valid yields the filler frame
            exp_q.push_back(rec_valid ? exp_of(rec_data) : exp_of({28'h100_0000, 28'h100_0000}));
        end
    end

    task automatic decode_frame();
        logic [55:0] got;
        logic [55:0] exp;
        logic [7:0]  pat;
        logic [7:0]  want;
        logic        ref_lvl;
        bit          edges_ok;
        got = '0;
        edges_ok = 1;
        for (int s = 0; s < 2; s++) begin
            int base = 64 * s;
            ref_lvl = (s == 0) ? pre_frame_lvl : lv[63];
            for (int k = 0; k < 8; k++) pat[7-k] = lv[base+k];
            if (s == 1) want = 8'b1110_0100;
            else if (fidx % 192 == 0) want = 8'b1110_1000;
            else want = 8'b1100_0010 | 8'b0010_0000;
            want = want ^ {8{ref_lvl}};
            check(pat == want, (s == 0 && fidx % 192 == 0) ? "R6 block sync" : "R5 sync", 64'(pat), 64'(want));
            for (int k = 4; k < 32; k++) begin
                if (lv[base+2*k] == lv[base+2*k-1]) edges_ok = 0;
                got[28*s + k - 4] = lv[base+2*k] ^ lv[base+2*k+1];
            end
        end
        check(edges_ok, "R4 cell edges", 64'(edges_ok), 64'd1);
        if (exp_q.size() == 0) begin
            check(0, "R2 no record expected", 64'(got), 64'd0);
        end else begin
            exp = exp_q.pop_front();
            check(got == exp, "R4/R7/R8 payload", 64'(got), 64'(exp));
        end
        fidx++;
    endtask

    task automatic wait_hs();
        forever begin
            @(negedge clk);
            if (ce && rec_ready) break;
        end
        @(posedge clk);
        #2;
        hs_cnt++;
    endtask

    task automatic send(logic [55:0] d);
        rec_valid = 1'b1;
        rec_data  = d;
        wait_hs();
        rec_valid = 1'b0;
    endtask

    task automatic idle(int n);
        rec_valid = 1'b0;
        for (int i = 0; i < n; i++) wait_hs();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        check(0, "watchdog", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check(sdo == 1'b0, "R1 reset level", 64'(sdo), 64'd0);
        check(rec_ready == ce, "R2 ready at first enable", 64'(rec_ready), 64'(ce));
        // R4 extreme payloads, R7 stored parity flipped on purpose
        send(56'h0);
        send({28'hFFF_FFFF, 28'hFFF_FFFF});
        send({28'h800_0001, 28'h0AA_AAAA});
        send({28'h7FF_FFFE, 28'h855_5555});
        // R8 underflow stretch
        idle(3);
        // R3 stalls inside and at frame boundaries
        ce_mode = 1;
        for (int i = 0; i < 4; i++) send(56'(i) * 56'h0123_4567_89AB_CD + 56'h11);
        ce_mode = 0;
        while (hs_cnt < 192) send(56'(hs_cnt) * 56'h009E_3779_B97F_4A + 56'h5A5A5);
        // R6 block start lands on filler frames
        idle(2);
        for (int i = 0; i < 3; i++) send(56'(i + 7) * 56'h00F0_F0F0_3C3C_3C);
        repeat (200) @(posedge clk);
        finish_run();
    end
endmodule